// File: doc/BRIEF.md
# Register-Driven I2C Master Front End

This block puts a small register file in front of a byte-level I2C bus engine. A host talks to it over a simple single-cycle register bus and sees five 16-bit registers: own address, clock divider, control, status and data. Every transfer is started by a register side effect. While the block is in the no-address state, the first data write after enabling master mode becomes a start-plus-address request. Later data writes become byte sends. A data read hands back the byte received last and, in receive mode, fetches the next byte.

Toward the bus engine the block issues four request kinds on a valid/ready channel: start (the byte carries the 7-bit target address and the direction), send, receive and stop. Each request is completed by a one-cycle done pulse that carries an ack bit and, for a receive, the received byte. One interrupt line reports finished address, send and receive phases. Clearing the enable bit while the block is enabled acts as a soft reset. Bit-level bus timing, clock division, slave operation and arbitration are left to the engine or are not present.

Top module: `i2c_host_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` is low and no engine request is pending.
- R2: Own address keeps 7 bits and the divider keeps 6 bits. Unused bits read 0. A write changes only the bytes whose `bus_be` lane is set (lane 0 is bits 7:0).
- R3: An access to an offset other than 0x00, 0x04, 0x08, 0x0C or 0x10, which includes misaligned offsets, reads 0 and raises `bus_err` for one cycle in the cycle after the access.
- R4: A write to data at 0x10 while control bit 0 (enable) is clear issues no engine request.
- R5: Status bit 2 (bus busy) follows control bit 2 (master) on every control write that is not a soft reset.
- R6: In master mode with no address latched, a data write issues a start request (op 0) carrying the written byte. A nack sets status bit 0 and leaves the block without an address. An ack clears status bit 0, latches the address and raises the interrupt.
- R7: With an address latched, a data write issues a send request (op 1). An ack clears status bit 0 and raises the interrupt. A nack sets status bit 0, issues a stop request (op 3) and returns the block to the no-address state.
- R8: An engine event sets status bit 1 (pending) and drives `irq` only when control bits 0 and 1 (interrupt enable) are both set. Writing 0 to status bit 1 while it is set clears the flag and drops `irq`.
- R9: In master mode, a data read returns the previously received byte. With an address latched and control bit 3 (transmit) clear, the read also issues a receive request (op 2), and the byte that comes back is what the next read returns.
- R10: A data read in master mode with no address latched, or with control bit 3 set, raises `bus_err` and issues no request.
- R11: A control write with bit 2 clear while an address is latched issues a stop request and clears the latched address.
- R12: A control write with bit 4 (restart) set while an address is latched issues a stop request, returns the block to the address phase and clears bit 4.
- R13: A control write with bit 0 clear while the block is enabled resets all state except the own address. If an address was latched, a stop request is issued.
- R14: A request is held stable until it is accepted. While a request is outstanding, status bit 3 (engine busy) reads 1 and data register accesses have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_off | input | OFF_W | Byte offset of the register |
| bus_be | input | REG_W/8 | Byte lane enables |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data of the addressed register (combinational) |
| bus_err | output | 1 | One-cycle pulse for a bad offset or an illegal data read |
| irq | output | 1 | Interrupt line |
| eng_req_valid | output | 1 | Engine request valid |
| eng_req_ready | input | 1 | Engine accepts the request |
| eng_req_op | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| eng_req_data | output | 8 | Address byte or data byte |
| eng_done | input | 1 | One-cycle completion of the accepted request |
| eng_ack | input | 1 | Ack result that goes with `eng_done` |
| eng_rdata | input | 8 | Received byte that goes with `eng_done` |

## Verification
The assertions assume that the engine sends exactly one `eng_done` per accepted request and never sends one while no request is outstanding. They also assume that a bus access lasts one cycle with at least one lane enabled. The bench's engine model accepts each request on the cycle it first sees it. It answers after a fixed latency, acks only target address 0x50 and byte values other than 0xEE, and returns received bytes that step by 0x11 from 0x3C. The bench issues register accesses one at a time, each separated by idle cycles, and lengthens the engine latency only for the busy-window test.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   typedef enum logic [1:0] {OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_STOP = 2'd3} eng_op_e;
   typedef enum logic [2:0] {K_IDLE, K_ADDR, K_SEND, K_RECV, K_STOP, K_DROP} wait_kind_e;
   typedef enum logic [2:0] {SEL_OWN, SEL_DIV, SEL_CTRL, SEL_STAT, SEL_DATA, SEL_NONE} reg_sel_e;

   localparam int CTRL_W   = 5;
   localparam int CB_EN    = 0;
   localparam int CB_IE    = 1;
   localparam int CB_MS    = 2;
   localparam int CB_TX    = 3;
   localparam int CB_RS    = 4;
   localparam int SB_NACK  = 0;
   localparam int SB_PEND  = 1;
   localparam int SB_BBUSY = 2;
   localparam int SB_EBUSY = 3;
endpackage

// File: rtl/i2cm_decode.sv
module i2cm_decode
   import i2cm_pkg::*;
#(
   parameter int OFF_W = 5
) (
   input  logic [OFF_W-1:0] off,
   output reg_sel_e         sel
);
   localparam int IW = OFF_W - 2;

   generate
      if (OFF_W < 5) begin : g_bad_off
         $error("i2cm_decode: OFF_W must be at least 5");
      end
   endgenerate

   logic [IW-1:0] idx;
   assign idx = off[OFF_W-1:2];

   always_comb begin
      sel = SEL_NONE;
      if (off[1:0] == 2'b00) begin
         case (idx)
            IW'(0):  sel = SEL_OWN;
            IW'(1):  sel = SEL_DIV;
            IW'(2):  sel = SEL_CTRL;
            IW'(3):  sel = SEL_STAT;
            IW'(4):  sel = SEL_DATA;
            default: sel = SEL_NONE;
         endcase
      end
   end
endmodule

// File: rtl/i2cm_lane_merge.sv
module i2cm_lane_merge #(
   parameter int REG_W = 16
) (
   input  logic [REG_W-1:0]   cur,
   input  logic [REG_W-1:0]   wdata,
   input  logic [REG_W/8-1:0] be,
   output logic [REG_W-1:0]   merged
);
   localparam int LANES = REG_W / 8;

   generate
      if ((REG_W % 8) != 0 || REG_W < 16) begin : g_bad_w
         $error("i2cm_lane_merge: REG_W must be a multiple of 8 and at least 16");
      end
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign merged[l*8 +: 8] = be[l] ? wdata[l*8 +: 8] : cur[l*8 +: 8];
      end
   endgenerate
endmodule

// File: rtl/i2cm_req_port.sv
module i2cm_req_port #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [1:0]        launch_op,
   input  logic [DATA_W-1:0] launch_data,
   input  logic              ready,
   output logic              valid,
   output logic [1:0]        op,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         op    <= '0;
         data  <= '0;
      end else if (launch) begin
         valid <= 1'b1;
         op    <= launch_op;
         data  <= launch_data;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end

   assert_req_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(op) && $stable(data)));

   assert_no_overlap_R14: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> !valid);
endmodule

// File: rtl/i2c_host_ctrl.sv
module i2c_host_ctrl
   import i2cm_pkg::*;
#(
   parameter int OFF_W = 5,
   parameter int REG_W = 16,
   parameter int OWN_W = 7,
   parameter int DIV_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [OFF_W-1:0]   bus_off,
   input  logic [REG_W/8-1:0] bus_be,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   output logic               bus_err,
   output logic               irq,
   output logic               eng_req_valid,
   input  logic               eng_req_ready,
   output logic [1:0]         eng_req_op,
   output logic [7:0]         eng_req_data,
   input  logic               eng_done,
   input  logic               eng_ack,
   input  logic [7:0]         eng_rdata
);
   localparam int LANES = REG_W / 8;

   generate
      if (OWN_W < 1 || OWN_W > REG_W) begin : g_bad_own
         $error("i2c_host_ctrl: OWN_W out of range");
      end
      if (DIV_W < 1 || DIV_W > REG_W) begin : g_bad_div
         $error("i2c_host_ctrl: DIV_W out of range");
      end
   endgenerate

   // register state
   logic [OWN_W-1:0]  own_q;
   logic [DIV_W-1:0]  div_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic              nack_q, pend_q, bbusy_q;
   logic              addr_valid_q, stop_pend_q, err_q;
   logic [7:0]        tx_q, rx_q;
   wait_kind_e        kind_q;

   // access decode
   reg_sel_e          sel;
   logic              acc, wr, rd;
   logic [REG_W-1:0]  rd_val, merged;

   i2cm_decode #(.OFF_W(OFF_W)) u_decode (.off(bus_off), .sel(sel));

   assign acc = bus_sel && (bus_be != '0);
   assign wr  = acc && bus_wr;
   assign rd  = acc && !bus_wr;

   logic eng_busy;
   assign eng_busy = (kind_q != K_IDLE) || stop_pend_q;

   always_comb begin
      rd_val = '0;
      case (sel)
         SEL_OWN:  rd_val = REG_W'(own_q);
         SEL_DIV:  rd_val = REG_W'(div_q);
         SEL_CTRL: rd_val = REG_W'(ctrl_q);
         SEL_STAT: rd_val = REG_W'({eng_busy, bbusy_q, pend_q, nack_q});
         SEL_DATA: rd_val = REG_W'(rx_q);
         default:  rd_val = '0;
      endcase
   end
   assign bus_rdata = rd_val;

   i2cm_lane_merge #(.REG_W(REG_W)) u_merge (
      .cur(rd_val), .wdata(bus_wdata), .be(bus_be[LANES-1:0]), .merged(merged));

   // request launch decision
   logic       launch, stop_launch, tx_load, rd_bad;
   eng_op_e    l_op;
   logic [7:0] l_data;
   wait_kind_e l_kind;

   always_comb begin
      launch      = 1'b0;
      stop_launch = 1'b0;
      tx_load     = 1'b0;
      rd_bad      = 1'b0;
      l_op        = OP_START;
      l_data      = bus_wdata[7:0];
      l_kind      = K_IDLE;
      if (wr && sel == SEL_DATA && ctrl_q[CB_EN] && !eng_busy) begin
         tx_load = 1'b1;
         if (ctrl_q[CB_MS]) begin
            launch = 1'b1;
            if (!addr_valid_q) begin
               l_op   = OP_START;
               l_kind = K_ADDR;
            end else begin
               l_op   = OP_SEND;
               l_kind = K_SEND;
            end
         end
      end
      if (rd && sel == SEL_DATA && ctrl_q[CB_MS] && !eng_busy) begin
         if (addr_valid_q && !ctrl_q[CB_TX]) begin
            launch = 1'b1;
            l_op   = OP_RECV;
            l_kind = K_RECV;
            l_data = 8'h00;
         end else begin
            rd_bad = 1'b1;
         end
      end
      if (kind_q == K_IDLE && stop_pend_q) begin
         launch      = 1'b1;
         stop_launch = 1'b1;
         l_op        = OP_STOP;
         l_kind      = K_STOP;
         l_data      = 8'h00;
      end
   end

   i2cm_req_port #(.DATA_W(8)) u_req (
      .clk(clk), .rst_n(rst_n), .launch(launch), .launch_op(l_op),
      .launch_data(l_data), .ready(eng_req_ready), .valid(eng_req_valid),
      .op(eng_req_op), .data(eng_req_data));

   logic raise_ok, drop_ok, stop_keep, soft_rst, host_err;
   assign raise_ok  = ctrl_q[CB_EN] && ctrl_q[CB_IE];
   assign drop_ok   = (kind_q != K_IDLE) && !eng_done;
   assign stop_keep = stop_pend_q && !stop_launch;
   assign soft_rst  = wr && sel == SEL_CTRL && ctrl_q[CB_EN] && !merged[CB_EN];
   assign host_err  = (acc && sel == SEL_NONE) || rd_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q        <= '0;
         div_q        <= '0;
         ctrl_q       <= '0;
         nack_q       <= 1'b0;
         pend_q       <= 1'b0;
         bbusy_q      <= 1'b0;
         addr_valid_q <= 1'b0;
         stop_pend_q  <= 1'b0;
         err_q        <= 1'b0;
         tx_q         <= '0;
         rx_q         <= '0;
         kind_q       <= K_IDLE;
      end else begin
         err_q <= host_err;
         if (launch)      kind_q <= l_kind;
         if (stop_launch) stop_pend_q <= 1'b0;
         if (tx_load)     tx_q <= bus_wdata[7:0];

         // engine completion
         if (eng_done && kind_q != K_IDLE) begin
            kind_q <= K_IDLE;
            case (kind_q)
               K_ADDR: begin
                  if (eng_ack) begin
                     nack_q       <= 1'b0;
                     addr_valid_q <= 1'b1;
                     if (raise_ok) pend_q <= 1'b1;
                  end else begin
                     nack_q <= 1'b1;
                  end
               end
               K_SEND: begin
                  if (eng_ack) begin
                     nack_q <= 1'b0;
                     if (raise_ok) pend_q <= 1'b1;
                  end else begin
                     nack_q       <= 1'b1;
                     addr_valid_q <= 1'b0;
                     stop_pend_q  <= 1'b1;
                  end
               end
               K_RECV: begin
                  rx_q <= eng_rdata;
                  if (raise_ok) pend_q <= 1'b1;
               end
               default: ;
            endcase
         end

         // register writes
         if (wr) begin
            case (sel)
               SEL_OWN: own_q <= merged[OWN_W-1:0];
               SEL_DIV: div_q <= merged[DIV_W-1:0];
               SEL_CTRL: begin
                  if (soft_rst) begin
                     ctrl_q       <= '0;
                     div_q        <= '0;
                     nack_q       <= 1'b0;
                     pend_q       <= 1'b0;
                     bbusy_q      <= 1'b0;
                     rx_q         <= '0;
                     tx_q         <= '0;
                     addr_valid_q <= 1'b0;
                     stop_pend_q  <= stop_keep || addr_valid_q;
                     if (drop_ok) kind_q <= K_DROP;
                  end else begin
                     ctrl_q  <= merged[CTRL_W-1:0];
                     bbusy_q <= merged[CB_MS];
                     if (addr_valid_q && (!merged[CB_MS] || merged[CB_RS])) begin
                        addr_valid_q <= 1'b0;
                        stop_pend_q  <= 1'b1;
                        if (merged[CB_RS]) ctrl_q[CB_RS] <= 1'b0;
                        if (drop_ok) kind_q <= K_DROP;
                     end
                  end
               end
               SEL_STAT: begin
                  if (pend_q && !merged[SB_PEND]) pend_q <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   assign irq     = pend_q;
   assign bus_err = err_q;

   assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ctrl_q[CB_EN] && ctrl_q[CB_IE]));

   assert_soft_keep_R13: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> ($stable(own_q) && ctrl_q == '0 && !irq));

   assert_off_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_DATA && !ctrl_q[CB_EN]) |=> ($stable(tx_q) && !eng_req_valid));

   assert_addr_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && kind_q == K_ADDR && !eng_ack) |=> !addr_valid_q);
endmodule

// File: tb/i2c_host_ctrl_bench.sv
module i2c_host_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_sel, bus_wr;
   logic [4:0]  bus_off;
   logic [1:0]  bus_be;
   logic [15:0] bus_wdata, bus_rdata;
   logic        bus_err, irq;
   logic        eng_req_valid, eng_req_ready;
   logic [1:0]  eng_req_op;
   logic [7:0]  eng_req_data;
   logic        eng_done, eng_ack;
   logic [7:0]  eng_rdata;

   always #5 clk = ~clk;

   i2c_host_ctrl u_i2c_host_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_off(bus_off), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq),
      .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
      .eng_req_op(eng_req_op), .eng_req_data(eng_req_data),
      .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata));

   int checks = 0;
   int errors = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // engine model: acks target 0x50 and bytes other than 0xEE
   int         n_ops = 0;
   int         last_op = -1;
   int         last_data = -1;
   int         eng_delay = 2;
   bit         m_busy = 1'b0;
   int         m_cnt = 0;
   logic [1:0] m_op;
   logic [7:0] m_data;
   logic [7:0] rx_seed = 8'h3C;

   initial begin
      eng_done  = 1'b0;
      eng_ack   = 1'b0;
      eng_rdata = 8'h00;
      eng_req_ready = 1'b1;
   end

   always @(negedge clk) begin
      eng_done = 1'b0;
      if (m_busy) begin
         if (m_cnt == 0) begin
            eng_done = 1'b1;
            m_busy   = 1'b0;
            case (m_op)
               2'd0: eng_ack = (m_data[7:1] == 7'h50);
               2'd1: eng_ack = (m_data != 8'hEE);
               2'd2: begin
                  eng_ack   = 1'b1;
                  eng_rdata = rx_seed;
                  rx_seed   = rx_seed + 8'h11;
               end
               default: eng_ack = 1'b1;
            endcase
         end else begin
            m_cnt--;
         end
      end else if (rst_n && eng_req_valid && eng_req_ready) begin
         m_busy    = 1'b1;
         m_cnt     = eng_delay;
         m_op      = eng_req_op;
         m_data    = eng_req_data;
         n_ops++;
         last_op   = int'(eng_req_op);
         last_data = int'(eng_req_data);
      end
   end

   logic [15:0] rv;
   logic        re;

   task automatic wr(input logic [4:0] off, input logic [15:0] d, input logic [1:0] be = 2'b11);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_off = off; bus_wdata = d; bus_be = be;
      @(negedge clk);
      re = bus_err;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] off);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_off = off; bus_be = 2'b11;
      #2 rv = bus_rdata;
      @(negedge clk);
      re = bus_err;
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   localparam logic [4:0] A_OWN = 5'h00, A_DIV = 5'h04, A_CTRL = 5'h08,
                          A_STAT = 5'h0C, A_DATA = 5'h10;

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int ops0;
      rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_off = '0; bus_be = '0; bus_wdata = '0;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset values
      rd(A_OWN);  chk("R1 own", rv, 0);
      rd(A_DIV);  chk("R1 div", rv, 0);
      rd(A_CTRL); chk("R1 ctrl", rv, 0);
      rd(A_STAT); chk("R1 stat", rv, 0);
      chk("R1 irq", irq, 0);
      chk("R1 no request", n_ops, 0);

      // R2 masks and lanes
      wr(A_OWN, 16'hFFFF); rd(A_OWN); chk("R2 own mask", rv, 16'h007F);
      wr(A_DIV, 16'hFFFF); rd(A_DIV); chk("R2 div mask", rv, 16'h003F);
      wr(A_OWN, 16'h0012, 2'b01); rd(A_OWN); chk("R2 own low lane", rv, 16'h0012);
      wr(A_OWN, 16'h00FF, 2'b10); rd(A_OWN); chk("R2 own high lane only", rv, 16'h0012);
      wr(A_DIV, 16'h0015, 2'b01); rd(A_DIV); chk("R2 div low lane", rv, 16'h0015);

      // R3 undefined offsets
      rd(5'h14); chk("R3 undefined reads zero", rv, 0); chk("R3 undefined err", re, 1);
      rd(5'h02); chk("R3 misaligned err", re, 1);
      rd(A_OWN); chk("R3 valid no err", re, 0);

      // R4 / R5: disabled master, data write ignored
      wr(A_CTRL, 16'h0004);
      rd(A_STAT); chk("R5 bus busy set", rv, 16'h0004);
      ops0 = n_ops;
      wr(A_DATA, 16'h00A0); idle(8);
      chk("R4 disabled write no request", n_ops, ops0);

      // R6 address phase
      wr(A_CTRL, 16'h0007);
      wr(A_DATA, 16'h0044); idle(8);
      chk("R6 start op", last_op, 0); chk("R6 start byte", last_data, 16'h44);
      rd(A_STAT); chk("R6 nack status", rv, 16'h0005); chk("R6 nack no irq", irq, 0);
      wr(A_DATA, 16'h00A0); idle(8);
      chk("R6 still address phase", last_op, 0);
      rd(A_STAT); chk("R6 ack status", rv, 16'h0006); chk("R6 ack irq", irq, 1);

      // R8 clear pending
      wr(A_STAT, 16'h0000); idle(1);
      chk("R8 irq cleared", irq, 0);
      rd(A_STAT); chk("R8 pending cleared", rv, 16'h0004);

      // R7 data phase
      wr(A_DATA, 16'h005A); idle(8);
      chk("R7 send op", last_op, 1); chk("R7 send byte", last_data, 16'h5A);
      rd(A_STAT); chk("R7 ack status", rv, 16'h0006);
      wr(A_STAT, 16'h0000);
      ops0 = n_ops;
      wr(A_DATA, 16'h00EE); idle(12);
      chk("R7 nack then stop count", n_ops, ops0 + 2); chk("R7 stop op", last_op, 3);
      rd(A_STAT); chk("R7 nack status", rv, 16'h0005);
      wr(A_DATA, 16'h00A1); idle(8);
      chk("R7 back to address phase", last_op, 0);
      rd(A_STAT); chk("R7 read-dir address ack", rv, 16'h0006);
      wr(A_STAT, 16'h0000);

      // R9 receive
      rd(A_DATA); chk("R9 first read old byte", rv, 0);
      idle(8);
      chk("R9 receive op", last_op, 2);
      rd(A_DATA); chk("R9 received byte", rv, 16'h003C);
      idle(8);
      chk("R9 second receive", last_op, 2);
      rd(A_DATA); chk("R9 next received byte", rv, 16'h004D);
      idle(8);
      wr(A_STAT, 16'h0000);

      // R10 read with transmit mode
      wr(A_CTRL, 16'h000F);
      ops0 = n_ops;
      rd(A_DATA); chk("R10 tx-mode read err", re, 1);
      idle(8); chk("R10 tx-mode read no request", n_ops, ops0);

      // R12 restart
      wr(A_CTRL, 16'h0017); idle(8);
      chk("R12 restart stop op", last_op, 3);
      rd(A_CTRL); chk("R12 restart bit clears", rv, 16'h0007);
      ops0 = n_ops;
      rd(A_DATA); chk("R10 no-address read err", re, 1);
      idle(8); chk("R10 no-address read no request", n_ops, ops0);
      wr(A_DATA, 16'h00A0); idle(8);
      chk("R12 address phase after restart", last_op, 0);
      wr(A_STAT, 16'h0000);

      // R11 master clear
      ops0 = n_ops;
      wr(A_CTRL, 16'h0003); idle(8);
      chk("R11 stop issued", last_op, 3); chk("R11 one request", n_ops, ops0 + 1);
      rd(A_STAT); chk("R11 bus busy cleared", rv, 16'h0000);
      wr(A_CTRL, 16'h0007);
      wr(A_DATA, 16'h0033); idle(8);
      chk("R11 next write is address", last_op, 0);

      // R8 interrupt gating
      wr(A_CTRL, 16'h0005);
      wr(A_DATA, 16'h00A0); idle(8);
      rd(A_STAT); chk("R8 gated no pending", rv, 16'h0004); chk("R8 gated irq low", irq, 0);

      // R14 busy window
      eng_delay = 20;
      ops0 = n_ops;
      wr(A_DATA, 16'h0077); idle(3);
      rd(A_STAT); chk("R14 engine busy bit", rv[3], 1);
      wr(A_DATA, 16'h0078); idle(30);
      chk("R14 second write ignored", n_ops, ops0 + 1);
      chk("R14 first byte sent", last_data, 16'h77);
      eng_delay = 2;

      // R13 soft reset
      wr(A_DIV, 16'h0009);
      ops0 = n_ops;
      wr(A_CTRL, 16'h0000); idle(8);
      rd(A_OWN);  chk("R13 own kept", rv, 16'h0012);
      rd(A_DIV);  chk("R13 div cleared", rv, 0);
      rd(A_CTRL); chk("R13 ctrl cleared", rv, 0);
      rd(A_STAT); chk("R13 stat cleared", rv, 0);
      chk("R13 stop issued", last_op, 3); chk("R13 one request", n_ops, ops0 + 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule